// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block produces the full timing of a successive-approximation analog-to-digital conversion. The analog clock is derived from the system clock by a programmable divider. After a start request the block runs a sample phase whose length can be extended, then makes one bit decision per result bit, MSB first, followed by one settling period. It finishes with a two-cycle tail that writes the result register and raises a done flag. The analog comparator, the capacitor array and the references are outside the block. The comparator's answer arrives as a single digital input, and the trial word it is compared against is presented on `sar_word`.

The divider ratio, the sample extension and the resolution (10-bit or 8-bit) are captured when a conversion is accepted. Two range flags from the analog front end force the result to zero or to full scale when the input lies outside the reference span.

Top module: `adc_seq`

## Requirements
- R1: While a conversion is running, `aclk_en` pulses for one system clock once every `div_cfg`+1 clocks. It pulses (13+`stc_cfg`) times in 10-bit mode and (11+`stc_cfg`) times in 8-bit mode.
- R2: `smp_phase` is high for exactly (`stc_cfg`+2)×(`div_cfg`+1) consecutive clocks, starting in the cycle after the edge that accepts `start`.
- R3: The result register is written exactly (`div_cfg`+1)×(13+`stc_cfg`)+1 clock edges after the accepting edge in 10-bit mode, and (`div_cfg`+1)×(11+`stc_cfg`)+1 edges after it in 8-bit mode. `done` is high in the cycle that follows the write.
- R4: `bit_strb` pulses once per result bit (10 or 8), never during the sample phase. `cmp_in`=1 means the input is at or above `sar_word`. Each decision keeps or clears the current trial bit and sets the next lower bit, so the result is the largest code not above the input.
- R5: With `res8`=1 the 8-bit result is left-aligned in bits 9..2, and bits 1..0 of `result` are 0.
- R6: `below_rng`=1 gives a result of 0. `above_rng`=1 gives 0x3FF in 10-bit mode and 0x3FC in 8-bit mode. In both cases `cmp_in` has no effect. The flags are captured at the end of the sample phase.
- R7: `load_strb` is high for one clock and `done` follows for exactly one clock. After that `busy` is low.
- R8: `start` is ignored while `busy` is high. `div_cfg`, `stc_cfg` and `res8` are captured only on the accepting edge.
- R9: Synchronous `rst` returns the block to idle and clears the divider counter and `result`. `busy`, `done` and `aclk_en` are then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request |
| div_cfg | input | 6 | Analog clock divider, ratio = value+1 |
| stc_cfg | input | 8 | Sample phase extension in analog periods |
| res8 | input | 1 | 1 = 8-bit, 0 = 10-bit resolution |
| cmp_in | input | 1 | Comparator result for the current trial word |
| below_rng | input | 1 | Input below reference ground |
| above_rng | input | 1 | Input above reference |
| aclk_en | output | 1 | Analog clock enable pulse |
| smp_phase | output | 1 | High during the sample phase |
| bit_strb | output | 1 | Bit decision strobe |
| sar_word | output | 10 | Current trial word for the DAC |
| load_strb | output | 1 | Result register load strobe |
| result | output | 10 | Result register |
| done | output | 1 | Conversion finished, one clock |
| busy | output | 1 | Conversion in progress |

## Verification
On every cycle, the embedded assertions check the following: the spacing of analog clock pulses, that bit strobes never fall in the sample phase, that the load is followed by a single-cycle `done`, and that the captured settings stay unchanged while busy. Only the bench's scenarios can show the rest. These are the exact cycle counts of the sample phase and of the whole conversion for each divider and extension value, the numeric result of the bit search, left alignment in 8-bit mode, saturation, and that a start request during a conversion leaves the timing untouched.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DIV_W   = 6,
  parameter int STC_W   = 8,
  parameter int RES_W   = 10,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [STC_W-1:0] stc_cfg,
  input  logic             res8,
  input  logic             cmp_in,
  input  logic             below_rng,
  input  logic             above_rng,
  output logic             aclk_en,
  output logic             smp_phase,
  output logic             bit_strb,
  output logic [RES_W-1:0] sar_word,
  output logic             load_strb,
  output logic [RES_W-1:0] result,
  output logic             done,
  output logic             busy
);
  localparam int CNT_W = STC_W + 1;
  localparam int LSB_S = RES_W - SHORT_W;

  typedef enum logic [2:0] {S_IDLE, S_SMP, S_CONV, S_LOAD, S_DONE} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_l, div_cnt;
  logic [STC_W-1:0] stc_l;
  logic             res8_l, sat_lo, sat_hi;
  logic [CNT_W-1:0] per_cnt;
  logic [RES_W-1:0] sar;

  int   nbits, lsb_pos, pos;
  logic cmp_eff, smp_end, conv_end;

  assign busy      = (st != S_IDLE);
  assign smp_phase = (st == S_SMP);
  assign aclk_en   = (st == S_SMP || st == S_CONV) && (div_cnt == div_l);
  assign bit_strb  = (st == S_CONV) && aclk_en && (int'(per_cnt) < nbits);
  assign load_strb = (st == S_LOAD);
  assign done      = (st == S_DONE);
  assign sar_word  = sar;
  assign cmp_eff   = sat_hi | (cmp_in & ~sat_lo);
  assign smp_end   = smp_phase && aclk_en && (per_cnt == CNT_W'(stc_l) + CNT_W'(1));
  assign conv_end  = (st == S_CONV) && aclk_en && (int'(per_cnt) == nbits);

  always_comb begin
    nbits   = res8_l ? SHORT_W : RES_W;
    lsb_pos = res8_l ? LSB_S : 0;
    pos     = RES_W - 1 - int'(per_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      div_cnt <= '0;
      per_cnt <= '0;
      div_l   <= '0;
      stc_l   <= '0;
      res8_l  <= 1'b0;
      sat_lo  <= 1'b0;
      sat_hi  <= 1'b0;
      sar     <= '0;
      result  <= '0;
    end else begin
      if (st == S_SMP || st == S_CONV)
        div_cnt <= (div_cnt == div_l) ? '0 : div_cnt + DIV_W'(1);
      case (st)
        S_IDLE: if (start) begin
          st      <= S_SMP;
          div_l   <= div_cfg;
          stc_l   <= stc_cfg;
          res8_l  <= res8;
          div_cnt <= '0;
          per_cnt <= '0;
        end
        S_SMP: if (smp_end) begin
          st      <= S_CONV;
          per_cnt <= '0;
          sar     <= RES_W'(1) << (RES_W - 1);
          sat_lo  <= below_rng;
          sat_hi  <= above_rng;
        end else if (aclk_en) per_cnt <= per_cnt + CNT_W'(1);
        S_CONV: if (conv_end) st <= S_LOAD;
        else if (aclk_en) begin
          per_cnt <= per_cnt + CNT_W'(1);
          for (int i = 0; i < RES_W; i++) begin
            if (i == pos) sar[i] <= cmp_eff;
            else if (i == pos - 1 && pos > lsb_pos) sar[i] <= 1'b1;
          end
        end
        S_LOAD: begin
          result <= sar;
          st     <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  div_period_chk: assert property (@(posedge clk) disable iff (rst)
    aclk_en && div_l != '0 |=> !aclk_en);
  // R4
  strb_phase_chk: assert property (@(posedge clk) disable iff (rst)
    bit_strb |-> !smp_phase && busy);
  // R7
  load_done_chk: assert property (@(posedge clk) disable iff (rst)
    load_strb |=> done && !load_strb);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(div_l) && $stable(stc_l) && $stable(res8_l));
  // R5
  short_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    done && res8_l |-> result[LSB_S-1:0] == '0);
endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  logic       clk = 0, rst = 1, start = 0, res8 = 0, below = 0, above = 0;
  logic [5:0] div_cfg = 0;
  logic [7:0] stc_cfg = 0;
  logic       cmp_in, aclk_en, smp_phase, bit_strb, load_strb, done, busy;
  logic [9:0] sar_word, result;
  logic [9:0] vin = 0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign cmp_in = (vin >= sar_word);

  adc_seq u_adc_seq (.clk, .rst, .start, .div_cfg, .stc_cfg, .res8, .cmp_in,
    .below_rng(below), .above_rng(above), .aclk_en, .smp_phase, .bit_strb,
    .sar_word, .load_strb, .result, .done, .busy);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int d, input int s, input bit r8, input int v,
                     input bit lo, input bit hi);
    int k = 0, n_acl = 0, n_smp = 0, n_bit = 0, n_load = 0, p, expv, nb;
    bit got = 0;
    nb = r8 ? 8 : 10;
    p = s + (r8 ? 11 : 13);
    expv = lo ? 0 : hi ? (r8 ? 10'h3FC : 10'h3FF) : (r8 ? (v & 10'h3FC) : v);
    @(negedge clk);
    div_cfg = 6'(d); stc_cfg = 8'(s); res8 = r8; vin = 10'(v);
    below = lo; above = hi; start = 1;
    @(posedge clk);
    // R8: changed settings and repeated start while busy
    @(negedge clk); div_cfg = 6'(d ^ 1); stc_cfg = 8'(s + 2); res8 = ~r8;
    while (!got && k < 40000) begin
      if (k == 3) start = 0;
      if (aclk_en) n_acl++;
      if (smp_phase) n_smp++;
      if (bit_strb) n_bit++;
      if (load_strb) n_load++;
      @(posedge clk); k++;
      @(negedge clk);
      if (done) got = 1;
    end
    start = 0;
    chk("R3 done edge", k, (d + 1) * p + 1);
    chk("R1 aclk count", n_acl, p);
    chk("R2 sample clocks", n_smp, (s + 2) * (d + 1));
    chk("R4 bit strobes", n_bit, nb);
    chk("R7 load count", n_load, 1);
    if (lo || hi) chk("R6 saturation", result, expv);
    else if (r8) chk("R5 left aligned", result, expv);
    else chk("R4 result", result, expv);
    @(negedge clk);
    chk("R7 done single", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R9 reset result", result, 0);
    chk("R9 reset flags", {busy, done, aclk_en}, 0);
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++)
        for (int r = 0; r < 2; r++) begin
          run(d, s, r[0], 10'h2A5, 0, 0);
          run(d, s, r[0], (d * 251 + s * 67 + 3) % 1024, 0, 0);
        end
    run(0, 0, 0, 0, 0, 0);
    run(0, 0, 0, 1023, 0, 0);
    run(1, 0, 1, 3, 0, 0);
    run(2, 1, 0, 500, 1, 0);
    run(2, 1, 0, 500, 0, 1);
    run(1, 2, 1, 700, 1, 0);
    run(1, 2, 1, 7, 0, 1);
    run(3, 0, 0, 10'h155, 0, 0);
    run(2, 3, 0, 10'h2AA, 0, 0);
    run(63, 255, 0, 10'h123, 0, 0);
    // R9: reset in mid conversion
    @(negedge clk); start = 1; div_cfg = 2; stc_cfg = 5; res8 = 0;
    repeat (20) @(negedge clk);
    start = 0; rst = 1;
    @(negedge clk); rst = 0;
    chk("R9 mid reset flags", {busy, done, aclk_en, smp_phase}, 0);
    chk("R9 mid reset result", result, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule